// File: doc/BRIEF.md
# Multiprocessor Interrupt Mask Controller

This block gathers the interrupt lines of a multiprocessor system and turns them into one 4-bit processor interrupt level (PIL) per CPU. The lines fall into three groups. Device lines and asynchronous error lines are shared by all CPUs. Software interrupts are private to each CPU. Each CPU also has its own level-14 timer line. Many lines share one level. Every shared line has its own bit in a global mask word, and bit 31 of that word blocks all shared lines at once.

Software changes the global mask only through two write ports. One port sets the bits written as one and the other clears them, so no read-modify-write is needed. Each CPU has its own state word with the same set and clear ports. That word holds the CPU's software interrupt requests and the mask bit of its level-14 timer. A target register picks the one CPU that receives device interrupts. Error interrupts go to every CPU. A pending register shows the raw state of the shared lines so that software can tell apart the sources that share a level.

The register port is a single-cycle word port with separate read and write strobes and no handshake. A read returns its data on `rdata_o` one clock after the strobe. The PIL outputs are combinational from the registers and the input lines.

Top module: `imc_top`

## Requirements
- R1: On reset the global mask reads 0xF87F_FFFF, which means bit 31, bits 30..27 and bits 22..0 are set and bits 26..23 read 0. Every per-CPU word reads 0x0000_0080, the target reads 0 and every PIL output is 0.
- R2: Writing to the mask-set port (word address 2) sets each implemented mask bit written as one. The other bits keep their value, and the mask changes only through the set and clear ports.
- R3: Writing to the mask-clear port (word address 3) clears each mask bit written as one and leaves the bits written as zero unchanged.
- R4: While global mask bit 31 is set, no shared line drives any PIL. Per-CPU software requests and unmasked level-14 timer requests still drive their own CPU's PIL.
- R5: Each shared device line has a fixed level. VME level n is at bit n and SBUS level n is at bit n+7 (n = 0..6), and both map n = 0..6 to PIL 2, 3, 5, 7, 9, 11, 13. Keyboard/mouse is bit 14 and serial is bit 15, both at PIL 12. Ethernet is bit 16 at PIL 6, audio bit 17 at 13, SCSI bit 18 at 4, system timer bit 19 at 10, video bit 20 at 8, module bit 21 at 9 and floppy bit 22 at 11. Lines 23..26 and 31 drive nothing.
- R6: The error lines 27..30 each drive PIL 15 on every CPU when their own mask bit and bit 31 are both clear.
- R7: An unmasked device line (bits 0..22) drives only the PIL of the CPU whose index is in the target register (word address 4, low bits). All other CPUs do not see it.
- R8: Each CPU word has a set port (0x10 + 4c + 1) and a clear port (0x10 + 4c + 2). Bit 16+k (k = 1..15) of the word is software interrupt k, and it drives PIL k on CPU c only.
- R9: Level-14 timer input c drives PIL 14 on CPU c when bit 7 of that CPU's word is clear. Setting bit 7 blocks it.
- R10: Each PIL output is the highest level among that CPU's active requests, or 0 when there are none.
- R11: The pending register (word address 0) reads the raw shared lines, unaffected by any mask. Bits 31 and 26..23 read 0.
- R12: A read strobe returns the addressed word on `rdata_o` at the next clock. Word address 1 reads the global mask and 0x10 + 4c reads CPU word c. Unmapped addresses read 0. Writes to read-only or unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the clock after the read strobe |
| src_i | input | 32 | Shared device and error interrupt lines, active high |
| tmr14_i | input | NCPU | Per-CPU level-14 timer lines |
| pil_o | output | 4*NCPU | Interrupt level per CPU, CPU c at bits 4c+3..4c |

## Verification
The bench checks that every device bit maps to its own level and that the level appears on the target CPU alone. A wrong table entry or a broadcast device line would put a level on the wrong output. It drives all lines high while bit 31 is set, then adds a software request, to catch a master mask that either misses a shared line or also blocks private requests. It writes to the read-only and unmapped addresses and reads back the pending word with the masks set, to expose decoding that lets such writes through or a pending view that applies the mask. A random phase mixes set and clear writes, target changes and line changes against a model of the registers. A wrong priority order then shows up as a lower level than expected whenever two requests overlap.

// File: rtl/imc_pkg.sv
package imc_pkg;

    localparam int WORD_W     = 32;
    localparam int PIL_W      = 4;
    localparam int NLVL       = 1 << PIL_W;

    localparam int MASTER_BIT = 31;
    localparam int L14_BIT    = 7;
    localparam int SOFT_LSB   = 16;

    localparam logic [WORD_W-1:0] GLOB_VALID = 32'hF87F_FFFF;
    localparam logic [WORD_W-1:0] PEND_VALID = 32'h787F_FFFF;
    localparam logic [WORD_W-1:0] ERR_BITS   = 32'h7800_0000;
    localparam logic [WORD_W-1:0] CPU_VALID  = 32'hFFFE_0080;
    localparam logic [WORD_W-1:0] CPU_RST    = 32'h0000_0080;

    localparam int A_PEND     = 0;
    localparam int A_MASK     = 1;
    localparam int A_MSET     = 2;
    localparam int A_MCLR     = 3;
    localparam int A_TGT      = 4;
    localparam int CPU_BASE   = 16;
    localparam int CPU_STRIDE = 4;
    localparam int CPU_RD     = 0;
    localparam int CPU_SET    = 1;
    localparam int CPU_CLR    = 2;

    // Level of a bus-leveled line with index n = 0..6
    function automatic logic [PIL_W-1:0] bus_level(input int n);
        if (n == 0) return PIL_W'(2);
        return PIL_W'(2 * n + 1);
    endfunction

    // Level driven by shared line b; 0 means the line drives nothing
    function automatic logic [PIL_W-1:0] src_level(input int b);
        logic [PIL_W-1:0] lv;
        if (b < 7)        lv = bus_level(b);
        else if (b < 14)  lv = bus_level(b - 7);
        else begin
            case (b)
                14, 15:         lv = PIL_W'(12);
                16:             lv = PIL_W'(6);
                17:             lv = PIL_W'(13);
                18:             lv = PIL_W'(4);
                19:             lv = PIL_W'(10);
                20:             lv = PIL_W'(8);
                21:             lv = PIL_W'(9);
                22:             lv = PIL_W'(11);
                27, 28, 29, 30: lv = PIL_W'(15);
                default:        lv = '0;
            endcase
        end
        return lv;
    endfunction

endpackage

// File: rtl/imc_regs.sv
module imc_regs
    import imc_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int ADDR_W = 8,
    parameter int CPU_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [WORD_W-1:0] src_i,
    output logic [WORD_W-1:0] mask_q,
    output logic [CPU_W-1:0]  target_q,
    output logic [WORD_W-1:0] cpu_q [NCPU],
    output logic [WORD_W-1:0] rdata_o
);

    localparam int CPU_END = CPU_BASE + NCPU * CPU_STRIDE;

    logic              in_cpu;
    logic [ADDR_W-1:0] cpu_off;
    logic [WORD_W-1:0] rd_mux;
    logic              wr_mset, wr_mclr, wr_tgt;

    assign in_cpu  = (int'(addr_i) >= CPU_BASE) && (int'(addr_i) < CPU_END);
    assign cpu_off = addr_i - ADDR_W'(CPU_BASE);
    assign wr_mset = wr_en_i && (int'(addr_i) == A_MSET);
    assign wr_mclr = wr_en_i && (int'(addr_i) == A_MCLR);
    assign wr_tgt  = wr_en_i && (int'(addr_i) == A_TGT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= GLOB_VALID;
        end else if (wr_mset) begin
            mask_q <= mask_q | (wdata_i & GLOB_VALID);
        end else if (wr_mclr) begin
            mask_q <= mask_q & ~(wdata_i & GLOB_VALID);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_q <= '0;
        end else if (wr_tgt) begin
            target_q <= wdata_i[CPU_W-1:0];
        end
    end

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu_word
        logic hit;
        assign hit = in_cpu && (cpu_off[ADDR_W-1:2] == (ADDR_W-2)'(c));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cpu_q[c] <= CPU_RST;
            end else if (wr_en_i && hit && (int'(cpu_off[1:0]) == CPU_SET)) begin
                cpu_q[c] <= cpu_q[c] | (wdata_i & CPU_VALID);
            end else if (wr_en_i && hit && (int'(cpu_off[1:0]) == CPU_CLR)) begin
                cpu_q[c] <= cpu_q[c] & ~(wdata_i & CPU_VALID);
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        case (int'(addr_i))
            A_PEND:  rd_mux = src_i & PEND_VALID;
            A_MASK:  rd_mux = mask_q;
            A_TGT:   rd_mux = WORD_W'(target_q);
            default: rd_mux = '0;
        endcase
        for (int c = 0; c < NCPU; c++) begin
            if (in_cpu && (cpu_off[ADDR_W-1:2] == (ADDR_W-2)'(c))
                       && (int'(cpu_off[1:0]) == CPU_RD)) begin
                rd_mux = cpu_q[c];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (rd_en_i) begin
            rdata_o <= rd_mux;
        end
    end

endmodule

// File: rtl/imc_route.sv
module imc_route
    import imc_pkg::*;
(
    input  logic [WORD_W-1:0] src_i,
    input  logic [WORD_W-1:0] mask_i,
    input  logic              tgt_hit_i,
    input  logic [15:1]       soft_i,
    input  logic              l14_mask_i,
    input  logic              tmr14_i,
    output logic [NLVL-1:0]   req_o
);

    always_comb begin
        req_o = '0;
        for (int b = 0; b < WORD_W; b++) begin
            if (src_i[b] && !mask_i[b] && !mask_i[MASTER_BIT]
                && (ERR_BITS[b] || tgt_hit_i)) begin
                req_o[src_level(b)] = 1'b1;
            end
        end
        for (int k = 1; k < NLVL; k++) begin
            if (soft_i[k]) req_o[k] = 1'b1;
        end
        if (tmr14_i && !l14_mask_i) req_o[14] = 1'b1;
        req_o[0] = 1'b0;
    end

endmodule

// File: rtl/imc_pil_enc.sv
module imc_pil_enc
    import imc_pkg::*;
(
    input  logic [NLVL-1:0]  req_i,
    output logic [PIL_W-1:0] pil_o
);

    always_comb begin
        pil_o = '0;
        for (int i = 1; i < NLVL; i++) begin
            if (req_i[i]) pil_o = PIL_W'(i);
        end
    end

endmodule

// File: rtl/imc_top.sv
module imc_top
    import imc_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int ADDR_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic                  rd_en_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [31:0]           wdata_i,
    output logic [31:0]           rdata_o,
    input  logic [31:0]           src_i,
    input  logic [NCPU-1:0]       tmr14_i,
    output logic [NCPU*4-1:0]     pil_o
);

    localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1;

    logic [WORD_W-1:0] mask_q;
    logic [CPU_W-1:0]  target_q;
    logic [WORD_W-1:0] cpu_q [NCPU];

    imc_regs #(
        .NCPU   (NCPU),
        .ADDR_W (ADDR_W),
        .CPU_W  (CPU_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en_i),
        .rd_en_i  (rd_en_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .src_i    (src_i),
        .mask_q   (mask_q),
        .target_q (target_q),
        .cpu_q    (cpu_q),
        .rdata_o  (rdata_o)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic [NLVL-1:0] req;

        imc_route u_route (
            .src_i      (src_i),
            .mask_i     (mask_q),
            .tgt_hit_i  (target_q == CPU_W'(c)),
            .soft_i     (cpu_q[c][SOFT_LSB+15:SOFT_LSB+1]),
            .l14_mask_i (cpu_q[c][L14_BIT]),
            .tmr14_i    (tmr14_i[c]),
            .req_o      (req)
        );

        imc_pil_enc u_enc (
            .req_i (req),
            .pil_o (pil_o[c*PIL_W +: PIL_W])
        );
    end

endmodule

// File: rtl/imc_chk.sv
module imc_chk
    import imc_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    input  logic [31:0]       rdata_o,
    input  logic [NCPU-1:0]   tmr14_i,
    input  logic [NCPU*4-1:0] pil_o,
    input  logic [31:0]       mask_q,
    input  logic [31:0]       cpu_q [NCPU]
);

    // R1
    mask_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask_q == GLOB_VALID));

    // R2
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && int'(addr_i) == A_MSET) |=>
        ((mask_q & $past(wdata_i & GLOB_VALID)) == $past(wdata_i & GLOB_VALID)));

    // R3
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && int'(addr_i) == A_MCLR) |=>
        ((mask_q & $past(wdata_i & GLOB_VALID)) == '0));

    // R2
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && (int'(addr_i) == A_MSET || int'(addr_i) == A_MCLR)) |=>
        $stable(mask_q));

    // R12
    rd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && int'(addr_i) == A_MASK) |=> (rdata_o == $past(mask_q)));

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu_chk
        // R4
        master_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_q[MASTER_BIT] && cpu_q[c][31:17] == '0 &&
             (cpu_q[c][L14_BIT] || !tmr14_i[c])) |-> (pil_o[c*4 +: 4] == 4'd0));

        // R8
        soft_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_q[c][31] |-> (pil_o[c*4 +: 4] == 4'd15));

        // R9
        l14_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tmr14_i[c] && !cpu_q[c][L14_BIT]) |-> (pil_o[c*4 +: 4] >= 4'd14));
    end

endmodule

bind imc_top imc_chk #(
    .NCPU   (NCPU),
    .ADDR_W (ADDR_W)
) u_imc_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .tmr14_i (tmr14_i),
    .pil_o   (pil_o),
    .mask_q  (mask_q),
    .cpu_q   (cpu_q)
);

// File: tb/test_imc_top.sv
`timescale 1ns/1ps
module test_imc_top;

    localparam int NCPU   = 4;
    localparam int ADDR_W = 8;
    localparam logic [31:0] GV = 32'hF87F_FFFF;
    localparam logic [31:0] CV = 32'hFFFE_0080;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic [31:0]       src = '0;
    logic [NCPU-1:0]   tmr = '0;
    logic [NCPU*4-1:0] pil;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] m_mask;
    logic [1:0]  m_tgt;
    logic [31:0] m_cpu [NCPU];

    always #2 clk = ~clk;

    imc_top #(.NCPU(NCPU), .ADDR_W(ADDR_W)) i_imc_top (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en),
        .rd_en_i (rd_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .src_i   (src),
        .tmr14_i (tmr),
        .pil_o   (pil)
    );

    function automatic int lvl_of(input int b);
        int tbl [0:6] = '{2, 3, 5, 7, 9, 11, 13};
        if (b <= 6) return tbl[b];
        if (b <= 13) return tbl[b-7];
        case (b)
            14, 15: return 12;
            16: return 6;
            17: return 13;
            18: return 4;
            19: return 10;
            20: return 8;
            21: return 9;
            22: return 11;
            27, 28, 29, 30: return 15;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_pil(input int c);
        int best = 0;
        for (int b = 0; b < 31; b++) begin
            if (src[b] && !m_mask[b] && !m_mask[31] && GV[b]
                && (b >= 27 || m_tgt == 2'(c)) && lvl_of(b) > best)
                best = lvl_of(b);
        end
        for (int k = 1; k < 16; k++)
            if (m_cpu[c][16+k] && k > best) best = k;
        if (tmr[c] && !m_cpu[c][7] && best < 14) best = 14;
        return best;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_pils(input string req);
        for (int c = 0; c < NCPU; c++)
            check(req, 32'(pil[c*4 +: 4]), 32'(exp_pil(c)));
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = ADDR_W'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 2) m_mask = m_mask | (d & GV);
        else if (a == 3) m_mask = m_mask & ~(d & GV);
        else if (a == 4) m_tgt = d[1:0];
        else if (a >= 16 && a < 16 + 4*NCPU) begin
            if ((a - 16) % 4 == 1) m_cpu[(a-16)/4] = m_cpu[(a-16)/4] | (d & CV);
            if ((a - 16) % 4 == 2) m_cpu[(a-16)/4] = m_cpu[(a-16)/4] & ~(d & CV);
        end
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = ADDR_W'(a);
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic drive(input logic [31:0] s, input logic [NCPU-1:0] t);
        @(negedge clk);
        src = s; tmr = t;
        #1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [31:0] x;
        void'($urandom(32'd20240611));
        m_mask = GV; m_tgt = '0;
        for (int c = 0; c < NCPU; c++) m_cpu[c] = 32'h80;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 pil", 32'(pil), 32'h0);
        rd(1, d); check("R1 mask", d, GV);
        rd(4, d); check("R1 target", d, 32'h0);
        for (int c = 0; c < NCPU; c++) begin
            rd(16 + 4*c, d); check("R1 cpu word", d, 32'h80);
        end

        // R11 pending is raw, ignores mask
        drive(32'hFFFF_FFFF, '0);
        check_pils("R11 masked pil");
        rd(0, d); check("R11 pending", d, 32'h787F_FFFF);
        drive(32'h0004_0081, '0);
        rd(0, d); check("R11 pending pattern", d, 32'h0004_0081);

        // R12 writes to read-only / unmapped addresses ignored
        wr(0, 32'h0);
        wr(1, 32'h0);
        wr(9, 32'hFFFF_FFFF);
        rd(1, d); check("R12 mask after RO write", d, GV);
        rd(9, d); check("R12 unmapped read", d, 32'h0);
        rd(16 + 4*NCPU, d); check("R12 past last cpu", d, 32'h0);

        // R3 clear all, R5 level per device bit, R7 on target only
        wr(3, 32'hFFFF_FFFF);
        rd(1, d); check("R3 mask cleared", d, 32'h0);
        for (int b = 0; b < 23; b++) begin
            drive(32'(1) << b, '0);
            check("R5 level", 32'(pil[3:0]), 32'(lvl_of(b)));
            check("R7 other cpu", 32'(pil[7:4]), 32'h0);
        end
        drive(32'h0780_0000, '0);
        check("R5 unused lines", 32'(pil), 32'h0);

        // R7 target steering
        wr(4, 32'h2);
        drive(32'h0004_0000, '0);
        check("R7 target cpu2", 32'(pil), 32'h0000_0400);

        // R6 errors broadcast
        drive(32'h1000_0000, '0);
        check("R6 broadcast", 32'(pil), 32'hFFFF);
        wr(2, 32'h1000_0000);
        check("R6 own mask", 32'(pil), 32'h0);
        wr(3, 32'h1000_0000);

        // R10 highest wins
        drive(32'h0003_0000, '0);
        check("R10 highest", 32'(pil[11:8]), 32'd13);

        // R2 set port, bits written zero unchanged
        wr(2, 32'h0002_0000);
        check("R10 next lower", 32'(pil[11:8]), 32'd6);
        rd(1, d); check("R2 set one bit", d, 32'h0002_0000);

        // R4 master mask, R8 soft still delivered on own cpu only
        wr(2, 32'h8000_0000);
        drive(32'hFFFF_FFFF, '0);
        check("R4 master blocks", 32'(pil), 32'h0);
        wr(16 + 4*1 + 1, 32'h1 << (16 + 5));
        check("R8 soft on cpu1", 32'(pil), 32'h0000_0050);
        rd(16 + 4*1, d); check("R8 cpu word", d, 32'h0020_0080);
        wr(16 + 4*1 + 2, 32'h1 << (16 + 5));
        check("R8 soft cleared", 32'(pil), 32'h0);

        // R9 level-14 timer
        drive(32'hFFFF_FFFF, 4'b1000);
        check("R9 timer masked", 32'(pil), 32'h0);
        wr(16 + 4*3 + 2, 32'h80);
        check("R9 timer unmasked", 32'(pil), 32'hE000);
        wr(16 + 4*3 + 1, 32'h80);
        check("R9 timer remasked", 32'(pil), 32'h0);

        // random phase, all requirements against the model
        for (int i = 0; i < 600; i++) begin
            int op;
            int c;
            op = int'($urandom % 8);
            c  = int'($urandom % NCPU);
            case (op)
                0: wr(2, $urandom & $urandom & $urandom);
                1: wr(3, $urandom);
                2: wr(4, $urandom);
                3: wr(16 + 4*c + 1, $urandom & $urandom & $urandom);
                4: wr(16 + 4*c + 2, $urandom);
                5: drive($urandom & $urandom, tmr);
                6: drive(src, NCPU'($urandom));
                default: begin
                    rd(1, d); check("R12 random mask read", d, m_mask);
                    rd(16 + 4*c, x); check("R8 random cpu read", x, m_cpu[c]);
                end
            endcase
            #1;
            check_pils("R10 random pil");
        end

        finish_run();
    end

endmodule